// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM with a 40-bit word and a configurable depth. The full array would hold 2M words. The default depth is small enough for simulation. Address and control are registered on the rising clock edge. Read data leaves through an output register. Write data follows its address by the same pipeline distance as read data, so the shared data path never needs an idle cycle when the direction changes.

A load cycle opens an access when all three chip selects are active. Advance cycles then step through a four-word burst in linear or interleaved order. The burst order is fixed when the burst is loaded. An active-low clock enable freezes every stage at once. This includes the output register, so the operation in progress is extended for as long as the enable stays inactive. Writes can be limited to any subset of six byte-like groups.

Top module: `pipe_sram`

## Requirements
- R1: While `rst` is high and after it drops, `dout_en` is 0 and `dout` is all zero until a read reaches the output stage.
- R2: A read command sampled at enabled edge k puts the word on `dout` after enabled edge k+2. The word is held there until the next enabled edge.
- R3: A load cycle (`adv_ld`=0) is an access only if `csel0_n`=0, `csel1`=1 and `csel2_n`=0. Any other combination writes nothing and returns no data.
- R4: A write (`we_n`=0) changes only the groups whose `wgrp_n[g]` bit is 0. Group g covers bits 7g to 7g+6, except group 5, which covers bits 35 to 39. Disabled groups keep their old content.
- R5: The data for a write command sampled at enabled edge k is taken from `din` at enabled edge k+2.
- R6: Reads and writes may follow each other on every enabled cycle in any order, with no idle cycle. A read issued right after a write to the same address returns the new data.
- R7: With `burst_ilv`=0 at load, each advance cycle (`adv_ld`=1) accesses the upper address bits of the load. The low two bits of the access are the start value plus n, modulo 4, where n is the advance count. The sequence wraps after the fourth word and keeps the direction (read or write) of the load.
- R8: With `burst_ilv`=1 at load, the low two bits of the n-th advance are the start value XOR n.
- R9: While `clk_en_n`=1, no input is sampled and every stage holds, including the output register. The `din` values driven during a stall are ignored.
- R10: `dout_en` is 1 only when `oe_n`=0 and the output stage holds a read. When `dout_en` is 0, `dout` is all zero.
- R11: During advance cycles the chip selects and `we_n` are ignored. An advance with no open burst (after reset or after a deselect) is not an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls all stages |
| csel0_n | input | 1 | Chip select, active low |
| csel1 | input | 1 | Chip select, active high |
| csel2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| we_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| wgrp_n | input | 6 | Active-low write enables, one per data group |
| addr | input | ADDR_W | Word address (ADDR_W = log2 DEPTH) |
| din | input | 40 | Write data, sampled two enabled cycles after its command |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 40 | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries a returned read word |

## Verification
The bench goes after a read that directly follows a write to the same address. A design that wrote too late would return the stale word there. It also checks bursts that start at a non-zero low address and wrap. A wrong sequencer would show up as a mixed-up linear or interleaved order, or as a burst that flips to read during an advance. Stalls are placed with a write and a read in flight. A design that let any stage slip, or that sampled `din` during a stall, would return shifted or corrupted words. Other checks cover partial group writes, each single chip select dropped, and advance cycles without an open burst. These expose stray writes, a misplaced group boundary, or output driven for writes or while `oe_n` is high.

// File: rtl/pssr_pkg.sv
`timescale 1ns/1ps
package pssr_pkg;

    localparam int DATA_W = 40;
    localparam int GRP_W  = 7;
    localparam int NGRP   = (DATA_W + GRP_W - 1) / GRP_W;

    typedef struct packed {
        logic            valid;
        logic            wr;
        logic [NGRP-1:0] grp;
    } cmd_t;

    // Width of one write group; the top group takes the remainder.
    function automatic int grp_width(int g);
        return (g == NGRP - 1) ? DATA_W - g * GRP_W : GRP_W;
    endfunction

    // Low two address bits of beat n of a burst starting at 'start'.
    function automatic logic [1:0] burst_lo(logic [1:0] start, logic [1:0] n, logic ilv);
        return ilv ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/pssr_cmd.sv
`timescale 1ns/1ps
module pssr_cmd
    import pssr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              sel_ok,
    input  logic              adv_ld,
    input  logic              burst_ilv,
    input  logic              we_n,
    input  logic [NGRP-1:0]   wgrp_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              s1,
    output logic [ADDR_W-1:0] s1_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        beat_q;
    logic              open_q;
    logic              bwr_q;
    logic              bilv_q;
    logic [1:0]        beat_nx;

    assign beat_nx = beat_q + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            beat_q  <= '0;
            open_q  <= 1'b0;
            bwr_q   <= 1'b0;
            bilv_q  <= 1'b0;
            s1      <= '0;
            s1_addr <= '0;
        end else if (ce) begin
            if (!adv_ld) begin
                if (sel_ok) begin
                    base_q    <= addr;
                    beat_q    <= 2'd0;
                    open_q    <= 1'b1;
                    bwr_q     <= ~we_n;
                    bilv_q    <= burst_ilv;
                    s1.valid  <= 1'b1;
                    s1.wr     <= ~we_n;
                    s1.grp    <= ~wgrp_n;
                    s1_addr   <= addr;
                end else begin
                    open_q    <= 1'b0;
                    s1.valid  <= 1'b0;
                    s1.wr     <= 1'b0;
                    s1.grp    <= '0;
                end
            end else if (open_q) begin
                beat_q    <= beat_nx;
                s1.valid  <= 1'b1;
                s1.wr     <= bwr_q;
                s1.grp    <= ~wgrp_n;
                s1_addr   <= {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], beat_nx, bilv_q)};
            end else begin
                s1.valid  <= 1'b0;
                s1.wr     <= 1'b0;
                s1.grp    <= '0;
            end
        end
    end

endmodule

// File: rtl/pssr_array.sv
`timescale 1ns/1ps
module pssr_array
    import pssr_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_q,
    output logic              rd_vld
);

    logic rd_go;
    assign rd_go = ce && cmd.valid && !cmd.wr;

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        localparam int LO = g * GRP_W;
        localparam int W  = grp_width(g);

        logic [W-1:0] bank [DEPTH];
        logic [W-1:0] slice_q;
        logic         wr_go;

        assign wr_go = ce && cmd.valid && cmd.wr && cmd.grp[g];

        always_ff @(posedge clk) begin
            if (wr_go) bank[addr] <= din[LO +: W];
        end

        always_ff @(posedge clk) begin
            if (rst)        slice_q <= '0;
            else if (rd_go) slice_q <= bank[addr];
        end

        assign rd_q[LO +: W] = slice_q;
    end

    always_ff @(posedge clk) begin
        if (rst)     rd_vld <= 1'b0;
        else if (ce) rd_vld <= cmd.valid && !cmd.wr;
    end

endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
    import pssr_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              csel0_n,
    input  logic              csel1,
    input  logic              csel2_n,
    input  logic              adv_ld,
    input  logic              burst_ilv,
    input  logic              we_n,
    input  logic [NGRP-1:0]   wgrp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              ce;
    logic              sel_ok;
    cmd_t              s1, s2;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [DATA_W-1:0] rd_q;
    logic              rd_vld;

    assign ce     = ~clk_en_n;
    assign sel_ok = ~csel0_n & csel1 & ~csel2_n;

    pssr_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .sel_ok    (sel_ok),
        .adv_ld    (adv_ld),
        .burst_ilv (burst_ilv),
        .we_n      (we_n),
        .wgrp_n    (wgrp_n),
        .addr      (addr),
        .s1        (s1),
        .s1_addr   (s1_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2      <= '0;
            s2_addr <= '0;
        end else if (ce) begin
            s2      <= s1;
            s2_addr <= s1_addr;
        end
    end

    pssr_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .cmd    (s2),
        .addr   (s2_addr),
        .din    (din),
        .rd_q   (rd_q),
        .rd_vld (rd_vld)
    );

    assign dout_en = rd_vld & ~oe_n;
    assign dout    = dout_en ? rd_q : '0;

endmodule

// File: rtl/pssr_chk.sv
`timescale 1ns/1ps
module pssr_chk
    import pssr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              sel_ok,
    input logic              oe_n,
    input cmd_t              s1,
    input cmd_t              s2,
    input logic [DATA_W-1:0] rd_q,
    input logic              rd_vld,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dout_en); // R1

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && s2.valid && !s2.wr) |=> rd_vld); // R2

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_ld && !sel_ok) |=> !s1.valid); // R3

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(rd_q) && $stable(rd_vld) && $stable(s1) && $stable(s2))); // R9

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && s2.valid && s2.wr) |=> !dout_en); // R10

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> !oe_n); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0)); // R10

endmodule

bind pipe_sram pssr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .sel_ok   (sel_ok),
    .oe_n     (oe_n),
    .s1       (s1),
    .s2       (s2),
    .rd_q     (rd_q),
    .rd_vld   (rd_vld),
    .dout     (dout),
    .dout_en  (dout_en)
);

// File: tb/pipe_sram_test.sv
`timescale 1ns/1ps
module pipe_sram_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en_n = 1'b0;
    logic        csel0_n = 1'b1;
    logic        csel1 = 1'b0;
    logic        csel2_n = 1'b1;
    logic        adv_ld = 1'b0;
    logic        burst_ilv = 1'b0;
    logic        we_n = 1'b1;
    logic [5:0]  wgrp_n = 6'h3F;
    logic [7:0]  addr = '0;
    logic [39:0] din = '0;
    logic        oe_n = 1'b0;
    logic [39:0] dout;
    logic        dout_en;

    int n_chk = 0;
    int n_bad = 0;
    int nstep = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pipe_sram uut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .csel0_n(csel0_n), .csel1(csel1), .csel2_n(csel2_n),
        .adv_ld(adv_ld), .burst_ilv(burst_ilv), .we_n(we_n),
        .wgrp_n(wgrp_n), .addr(addr), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en)
    );

    // Reference model state
    logic [39:0] mdl [256];
    bit          m1_v, m1_w, m2_v, m2_w;
    logic [5:0]  m1_g, m2_g;
    logic [7:0]  m1_a, m2_a;
    bit          b_on, b_wr, b_ilv;
    logic [7:0]  b_base;
    logic [1:0]  b_cnt;
    bit          e_rd;
    logic [39:0] e_dat;

    task automatic compare(input string tag, input logic [40:0] act, input logic [40:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got en=%0b data=%h, expected en=%0b data=%h",
                     tag, act[40], act[39:0], exp[40], exp[39:0]);
        end
    endtask

    task automatic step(input bit en, input bit [2:0] sel, input bit wr, input bit [5:0] grp,
                        input bit adv, input bit ilv, input logic [7:0] a, input bit oe,
                        input string tag);
        bit          n_v, n_w;
        logic [7:0]  n_a;
        logic [39:0] d;
        bit          x_en;
        @(negedge clk);
        nstep++;
        d = {nstep[7:0], nstep[15:0] * 16'h9E37, nstep[15:0] ^ 16'hC3A5};
        clk_en_n = !en; csel0_n = !sel[0]; csel1 = sel[1]; csel2_n = !sel[2];
        we_n = !wr; wgrp_n = ~grp; adv_ld = adv; burst_ilv = ilv; addr = a;
        din = d; oe_n = !oe;
        @(posedge clk);
        if (en) begin
            if (m2_v && m2_w)
                for (int i = 0; i < 40; i++) if (m2_g[i / 7]) mdl[m2_a][i] = d[i];
            e_rd = m2_v && !m2_w;
            if (e_rd) e_dat = mdl[m2_a];
            m2_v = m1_v; m2_w = m1_w; m2_g = m1_g; m2_a = m1_a;
            n_v = 0; n_w = 0; n_a = a;
            if (!adv) begin
                if (&sel) begin
                    b_on = 1; b_base = a; b_cnt = 0; b_wr = wr; b_ilv = ilv;
                    n_v = 1; n_w = wr; n_a = a;
                end else b_on = 0;
            end else if (b_on) begin
                b_cnt = b_cnt + 2'd1;
                n_a = {b_base[7:2], b_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
                n_v = 1; n_w = b_wr;
            end
            m1_v = n_v; m1_w = n_w; m1_g = grp; m1_a = n_a;
        end
        #2;
        x_en = e_rd && oe;
        compare(tag, {dout_en, dout}, {x_en, x_en ? e_dat : 40'h0});
    endtask

    task automatic ld(input bit wr, input bit [5:0] grp, input logic [7:0] a, input bit ilv,
                      input string tag);
        step(1, 3'b111, wr, grp, 0, ilv, a, 1, tag);
    endtask

    // advance with selects dropped and we_n high: both must be ignored (R11)
    task automatic adv(input bit [5:0] grp, input string tag);
        step(1, 3'b000, 0, grp, 1, 0, 8'h00, 1, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 3'b000, 0, 6'h00, 0, 0, 8'h00, 1, tag);
    endtask

    task automatic stall(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 3'b111, 1, 6'h3F, 0, 0, 8'hFF, 1, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        compare("R1 during reset", {dout_en, dout}, 41'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        compare("R1 after reset", {dout_en, dout}, 41'h0);
        idle(2, "R1 idle");
    endtask

    task automatic t_basic;
        ld(1, 6'h3F, 8'd20, 0, "R5 write");
        ld(1, 6'h3F, 8'd21, 0, "R5 write");
        ld(1, 6'h3F, 8'd22, 0, "R5 write");
        idle(2, "R5 drain");
        ld(0, 6'h00, 8'd20, 0, "R2 read");
        ld(0, 6'h00, 8'd21, 0, "R2 read");
        ld(0, 6'h00, 8'd22, 0, "R2 read");
        idle(3, "R2 result");
    endtask

    task automatic t_turn;
        ld(1, 6'h3F, 8'd40, 0, "R6 w");
        ld(0, 6'h00, 8'd40, 0, "R6 raw");
        ld(1, 6'h3F, 8'd41, 0, "R6 w");
        ld(0, 6'h00, 8'd40, 0, "R6 r");
        ld(0, 6'h00, 8'd41, 0, "R6 raw");
        ld(1, 6'h3F, 8'd40, 0, "R6 w");
        ld(0, 6'h00, 8'd40, 0, "R6 raw");
        ld(1, 6'h3F, 8'd41, 0, "R6 w");
        idle(3, "R6 result");
    endtask

    task automatic t_groups;
        ld(1, 6'h3F, 8'd60, 0, "R4 fill");
        idle(2, "R4 drain");
        ld(1, 6'b000001, 8'd60, 0, "R4 grp0");
        ld(1, 6'b100000, 8'd60, 0, "R4 grp5");
        ld(1, 6'b010100, 8'd60, 0, "R4 grp2+4");
        ld(1, 6'b000000, 8'd60, 0, "R4 none");
        ld(0, 6'h00, 8'd60, 0, "R4 readback");
        idle(3, "R4 result");
        for (int g = 0; g < 6; g++) begin
            ld(1, 6'h3F, 8'd61, 0, "R4 refill");
            ld(1, 6'(1 << g), 8'd61, 0, "R4 single grp");
            ld(0, 6'h00, 8'd61, 0, "R4 single readback");
        end
        idle(3, "R4 result");
    endtask

    task automatic t_select;
        ld(1, 6'h3F, 8'd80, 0, "R3 fill");
        idle(2, "R3 drain");
        step(1, 3'b110, 1, 6'h3F, 0, 0, 8'd80, 1, "R3 sel0 off");
        step(1, 3'b101, 1, 6'h3F, 0, 0, 8'd80, 1, "R3 sel1 off");
        step(1, 3'b011, 1, 6'h3F, 0, 0, 8'd80, 1, "R3 sel2 off");
        step(1, 3'b011, 0, 6'h00, 0, 0, 8'd80, 1, "R3 read desel");
        idle(2, "R3 nothing out");
        ld(0, 6'h00, 8'd80, 0, "R3 readback");
        idle(3, "R3 result");
    endtask

    task automatic t_burst_lin;
        ld(1, 6'h3F, 8'h32, 0, "R7 wr load");
        adv(6'h3F, "R7 wr beat");
        adv(6'h3F, "R7 wr beat");
        adv(6'h3F, "R7 wr beat");
        idle(2, "R7 drain");
        for (int i = 0; i < 4; i++) ld(0, 6'h00, 8'(8'h30 + i), 0, "R7 single read");
        ld(0, 6'h00, 8'h31, 0, "R7 rd load");
        for (int i = 0; i < 4; i++) adv(6'h00, "R7 rd beat wrap");
        idle(3, "R7 result");
    endtask

    task automatic t_burst_ilv;
        ld(1, 6'h3F, 8'h45, 1, "R8 wr load");
        adv(6'h3F, "R8 wr beat");
        adv(6'h3F, "R8 wr beat");
        adv(6'h3F, "R8 wr beat");
        idle(2, "R8 drain");
        for (int i = 0; i < 4; i++) ld(0, 6'h00, 8'(8'h44 + i), 0, "R8 single read");
        ld(0, 6'h00, 8'h47, 1, "R8 rd load");
        for (int i = 0; i < 4; i++) adv(6'h00, "R8 rd beat");
        idle(3, "R8 result");
    endtask

    task automatic t_adv_idle;
        idle(1, "R11 close");
        adv(6'h3F, "R11 adv closed");
        adv(6'h3F, "R11 adv closed");
        idle(2, "R11 nothing out");
        ld(0, 6'h00, 8'h30, 0, "R11 load");
        adv(6'h00, "R11 sel ignored");
        idle(3, "R11 result");
    endtask

    task automatic t_stall;
        ld(1, 6'h3F, 8'h90, 0, "R9 w");
        stall(2, "R9 stall");
        ld(0, 6'h00, 8'd20, 0, "R9 r");
        stall(3, "R9 stall");
        ld(0, 6'h00, 8'h90, 0, "R9 r new");
        idle(1, "R9 out");
        stall(3, "R9 hold out");
        idle(3, "R9 result");
    endtask

    task automatic t_oe;
        ld(0, 6'h00, 8'd20, 0, "R10 r");
        ld(0, 6'h00, 8'd21, 0, "R10 r");
        step(1, 3'b000, 0, 6'h00, 0, 0, 8'h00, 0, "R10 oe off");
        step(1, 3'b000, 0, 6'h00, 0, 0, 8'h00, 1, "R10 oe on");
        ld(1, 6'h3F, 8'd22, 0, "R10 w");
        idle(3, "R10 write silent");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_turn();
        t_groups();
        t_select();
        t_burst_lin();
        t_burst_ilv();
        t_adv_idle();
        t_stall();
        t_oe();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule